// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This unit holds a small bank of data address comparators that monitor the core's load and store traffic. Every slot owns three registers: a compare value, an ignore-width and a function select. The slot fires when a valid access falls inside its watched region and has the direction that its function select asks for. Any firing slot raises a one-cycle debug event toward the debug monitor exception logic. The slot also records the hit in a sticky status bit, which software clears by reading that slot's function register.

The whole comparator bank works only while the external trace enable level is high. The registers stay readable and writable when it is low. Address masking removes a programmable number of low address bits before the compare, so one slot can cover any naturally aligned power-of-two region.

Top module: `dwatch_unit`

## Requirements
- R1: After synchronous reset every compare, ignore-width and function register reads 0, all status bits are 0 and the debug event is low.
- R2: A slot hits when (access address AND (all-ones shifted left by its ignore-width value n)) equals its compare value, so the low n address bits are ignored.
- R3: Function code 5 hits on write accesses (wr=1) only.
- R4: Function code 6 hits on read accesses (wr=0) only.
- R5: Function code 7 hits on reads and writes alike.
- R6: Function code 0, and every code other than 5, 6 and 7, never hits.
- R7: While trace enable is low no slot hits, no status bit sets and no debug event is raised.
- R8: The debug event is high for exactly the one cycle after the clock edge that samples a valid access hitting at least one slot, and low otherwise.
- R9: A hit sets the slot's status bit at that same edge. The bit stays set until the slot's function register is read, and the read clears it at the clock edge. It appears on the slot_hit output (bit i for slot i) and at bit 31 of the function register readback.
- R10: A write to a function register updates only its code field, bits [3:0]. Other write data bits are dropped, and the status bit keeps its value.
- R11: The register word address is slot*4 + sel, where sel 0 selects compare, 1 the ignore-width (bits [4:0]) and 2 the function register. sel 3 reads 0, and read data is combinational from reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_en | input | 1 | Enables the comparator bank |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Data access address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect: status clear) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| slot_hit | output | 4 | Per-slot sticky status |
| dbg_event | output | 1 | Debug event to the monitor controller |

## Verification
The bench builds the unit with its defaults: four slots, 32-bit addresses and a 5-bit ignore-width. This gives one slot for each function code class: writes only, reads only, both directions, and an illegal code. Ignore-widths of 0, 4 and 12 exercise exact, small-region and page-sized matches, including addresses just past a region's edge. With several slots live, a single access can hit more than one slot at once, and the status clear of one slot can be checked while the others keep their bits.

// File: rtl/dwatch_pkg.sv
// Package: shared constants for the data watchpoint unit.
// Assumes function codes fit in 4 bits and register select uses 2 bits.
package dwatch_pkg;
    localparam int FUNC_W   = 4;
    localparam int SEL_W    = 2;

    localparam logic [FUNC_W-1:0] FN_OFF   = 4'd0;
    localparam logic [FUNC_W-1:0] FN_WRITE = 4'd5;
    localparam logic [FUNC_W-1:0] FN_READ  = 4'd6;
    localparam logic [FUNC_W-1:0] FN_ANY   = 4'd7;

    typedef enum logic [SEL_W-1:0] {
        SEL_COMP = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FUNC = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dwatch_cmp.sv
// Module: one slot's address comparator.
// Masks the low MASK bits of the access address, compares against the
// stored value and qualifies the result with direction and trace enable.
// Purely combinational; assumes inputs are stable around the clock edge.
module dwatch_cmp #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 5
) (
    input  logic [ADDR_W-1:0]             comp,
    input  logic [MASK_W-1:0]             mask,
    input  logic [dwatch_pkg::FUNC_W-1:0] func,
    input  logic                          trace_en,
    input  logic                          acc_valid,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic                          acc_wr,
    output logic                          hit
);
    import dwatch_pkg::*;

    logic [ADDR_W-1:0] keep_bits;
    logic              addr_eq;
    logic              dir_ok;

    // Build the address keep-mask and compare the region.
    always_comb begin
        keep_bits = {ADDR_W{1'b1}} << mask;
        addr_eq   = ((acc_addr & keep_bits) == comp);
    end

    // Decode the function code into a direction qualifier.
    always_comb begin
        case (func)
            FN_WRITE: dir_ok = acc_wr;
            FN_READ:  dir_ok = !acc_wr;
            FN_ANY:   dir_ok = 1'b1;
            default:  dir_ok = 1'b0;
        endcase
    end

    // Final slot hit, gated by enable and strobe.
    always_comb begin
        hit = trace_en && acc_valid && addr_eq && dir_ok;
    end
endmodule

// File: rtl/dwatch_slot.sv
// Module: register state of one watch slot.
// Holds the compare value, ignore-width, function code and sticky status.
// A function write updates only the code field; a function read clears
// the status unless a new hit arrives in the same cycle.
module dwatch_slot #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_comp,
    input  logic                          wr_mask,
    input  logic                          wr_func,
    input  logic [ADDR_W-1:0]             wdata,
    input  logic                          rd_func,
    input  logic                          hit,
    output logic [ADDR_W-1:0]             comp_q,
    output logic [MASK_W-1:0]             mask_q,
    output logic [dwatch_pkg::FUNC_W-1:0] func_q,
    output logic                          stat_q
);
    import dwatch_pkg::*;

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)       comp_q <= '0;
        else if (wr_comp) comp_q <= wdata;
    end

    // Ignore-width register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata[MASK_W-1:0];
    end

    // Function code field; other write bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       func_q <= FN_OFF;
        else if (wr_func) func_q <= wdata[FUNC_W-1:0];
    end

    // Sticky status: set on hit, cleared by a function read.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (hit)     stat_q <= 1'b1;
        else if (rd_func) stat_q <= 1'b0;
    end
endmodule

// File: rtl/dwatch_regif.sv
// Module: register decode and read mux.
// Word address = slot*4 + sel. Produces per-slot write and read strobes
// and the combinational read data. Assumes NUM_SLOTS is a power of two.
module dwatch_regif #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int MASK_W    = 5,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int RA_W     = SLOT_W + dwatch_pkg::SEL_W
) (
    input  logic                                         reg_wr,
    input  logic                                         reg_rd,
    input  logic [RA_W-1:0]                              reg_addr,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]             comp_q,
    input  logic [NUM_SLOTS-1:0][MASK_W-1:0]             mask_q,
    input  logic [NUM_SLOTS-1:0][dwatch_pkg::FUNC_W-1:0] func_q,
    input  logic [NUM_SLOTS-1:0]                         stat_q,
    output logic [NUM_SLOTS-1:0]                         wr_comp,
    output logic [NUM_SLOTS-1:0]                         wr_mask,
    output logic [NUM_SLOTS-1:0]                         wr_func,
    output logic [NUM_SLOTS-1:0]                         rd_func,
    output logic [ADDR_W-1:0]                            rdata
);
    import dwatch_pkg::*;

    logic [SLOT_W-1:0] slot_idx;
    reg_sel_e          sel;

    // Split the word address into slot index and register select.
    always_comb begin
        slot_idx = reg_addr[RA_W-1:SEL_W];
        sel      = reg_sel_e'(reg_addr[SEL_W-1:0]);
    end

    // Per-slot strobes.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            wr_comp[i] = reg_wr && (slot_idx == SLOT_W'(i)) && (sel == SEL_COMP);
            wr_mask[i] = reg_wr && (slot_idx == SLOT_W'(i)) && (sel == SEL_MASK);
            wr_func[i] = reg_wr && (slot_idx == SLOT_W'(i)) && (sel == SEL_FUNC);
            rd_func[i] = reg_rd && (slot_idx == SLOT_W'(i)) && (sel == SEL_FUNC);
        end
    end

    // Read data mux; the status bit sits in the top bit of the function word.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_COMP: rdata = comp_q[slot_idx];
            SEL_MASK: rdata[MASK_W-1:0] = mask_q[slot_idx];
            SEL_FUNC: begin
                rdata[FUNC_W-1:0] = func_q[slot_idx];
                rdata[ADDR_W-1]   = stat_q[slot_idx];
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dwatch_unit.sv
// Module: data watchpoint unit top.
// Instantiates NUM_SLOTS comparator slots, the register decode and the
// debug event register. The event is a one-cycle pulse, registered one
// edge after a qualifying access. Assumes ADDR_W > FUNC_W + 1.
module dwatch_unit #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int MASK_W    = 5,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int RA_W     = SLOT_W + dwatch_pkg::SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trace_en,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 acc_wr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output logic                 dbg_event
);
    import dwatch_pkg::*;

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] comp_q;
    logic [NUM_SLOTS-1:0][MASK_W-1:0] mask_q;
    logic [NUM_SLOTS-1:0][FUNC_W-1:0] func_q;
    logic [NUM_SLOTS-1:0]             stat_q;
    logic [NUM_SLOTS-1:0]             wr_comp, wr_mask, wr_func, rd_func;
    logic [NUM_SLOTS-1:0]             hit;
    logic                             event_q;

    dwatch_regif #(
        .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
    ) u_regif (
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .comp_q(comp_q), .mask_q(mask_q), .func_q(func_q), .stat_q(stat_q),
        .wr_comp(wr_comp), .wr_mask(wr_mask), .wr_func(wr_func),
        .rd_func(rd_func), .rdata(reg_rdata)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        dwatch_slot #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_comp(wr_comp[g]), .wr_mask(wr_mask[g]), .wr_func(wr_func[g]),
            .wdata(reg_wdata), .rd_func(rd_func[g]), .hit(hit[g]),
            .comp_q(comp_q[g]), .mask_q(mask_q[g]), .func_q(func_q[g]),
            .stat_q(stat_q[g])
        );

        dwatch_cmp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_cmp (
            .comp(comp_q[g]), .mask(mask_q[g]), .func(func_q[g]),
            .trace_en(trace_en), .acc_valid(acc_valid),
            .acc_addr(acc_addr), .acc_wr(acc_wr), .hit(hit[g])
        );
    end

    // Debug event: one-cycle pulse after any slot hits.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= 1'b0;
        else        event_q <= |hit;
    end

    // Output drives.
    always_comb begin
        dbg_event = event_q;
        slot_hit  = stat_q;
    end
endmodule

// File: rtl/dwatch_unit_checks.sv
// Checker: temporal properties of the watchpoint unit, bound to the top.
module dwatch_unit_checks #(
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trace_en,
    input logic                 acc_valid,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [NUM_SLOTS-1:0] slot_hit,
    input logic                 dbg_event
);
    // R8: an event needs a valid access in the previous cycle.
    a_r8_event_has_access: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event |-> $past(acc_valid && trace_en));

    // R7: no event after a cycle with trace disabled.
    a_r7_gated_by_trace: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> !dbg_event);

    // R8: an event comes with at least one status bit set.
    a_r8_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event |-> (slot_hit != '0));

    // R9: without a read, no status bit ever clears.
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> ((slot_hit & $past(slot_hit)) == $past(slot_hit)));

    // R10: a register write with no access and no read leaves status alone.
    a_r10_write_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !acc_valid) |=> $stable(slot_hit));

    // R7: status bits cannot rise while trace is off.
    a_r7_no_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> ((slot_hit & ~$past(slot_hit)) == '0));
endmodule

bind dwatch_unit dwatch_unit_checks #(.NUM_SLOTS(NUM_SLOTS)) u_checks (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .acc_valid(acc_valid),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .slot_hit(slot_hit),
    .dbg_event(dbg_event)
);

// File: tb/dwatch_unit_test.sv
// Bench: scoreboard-driven test of the data watchpoint unit.
module dwatch_unit_test;
    localparam int NS = 4;
    localparam int AW = 32;

    typedef struct packed {
        logic          ev;
        logic [NS-1:0] st;
        logic [7:0]    req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 1'b0, acc_valid = 1'b0, acc_wr = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] acc_addr = '0, reg_wdata = '0;
    logic [3:0] reg_addr = '0;
    logic [AW-1:0] reg_rdata;
    logic [NS-1:0] slot_hit;
    logic dbg_event;

    int checks = 0, errors = 0;
    exp_t sb_q[$];

    logic [AW-1:0] m_comp [NS];
    logic [4:0]    m_mask [NS];
    logic [3:0]    m_func [NS];
    logic [NS-1:0] m_stat = '0;

    always #4 clk = ~clk;

    dwatch_unit uut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_wr(acc_wr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_hit(slot_hit), .dbg_event(dbg_event)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit model_hit(int s, logic [AW-1:0] a, logic w);
        bit dir;
        case (m_func[s])
            4'd5: dir = w;
            4'd6: dir = !w;
            4'd7: dir = 1'b1;
            default: dir = 1'b0;
        endcase
        return trace_en && dir && ((a & ({AW{1'b1}} << m_mask[s])) == m_comp[s]);
    endfunction

    task automatic reg_write(input int s, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(s * 4 + sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel == 0) m_comp[s] = d;
        else if (sel == 1) m_mask[s] = d[4:0];
        else if (sel == 2) m_func[s] = d[3:0];
    endtask

    task automatic reg_read(input int s, input int sel, input string req);
        logic [AW-1:0] exp;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(s * 4 + sel);
        case (sel)
            0: exp = m_comp[s];
            1: exp = {27'd0, m_mask[s]};
            2: exp = {m_stat[s], 27'd0, m_func[s]};
            default: exp = '0;
        endcase
        #1 check(reg_rdata === exp, req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
        if (sel == 2) m_stat[s] = 1'b0;
    endtask

    // Driver: issues one access and pushes the expected outcome.
    task automatic access(input logic [AW-1:0] a, input logic w, input logic [7:0] req);
        exp_t e;
        logic [NS-1:0] h = '0;
        @(negedge clk);
        for (int s = 0; s < NS; s++) h[s] = model_hit(s, a, w);
        acc_valid = 1'b1; acc_addr = a; acc_wr = w;
        m_stat = m_stat | h;
        e.ev = |h; e.st = m_stat; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: pops each expectation after the registering edge.
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            @(posedge clk);
            #1;
            e = sb_q.pop_front();
            check(dbg_event === e.ev, $sformatf("R%0d event", e.req),
                  AW'(dbg_event), AW'(e.ev));
            check(slot_hit === e.st, $sformatf("R%0d status", e.req),
                  AW'(slot_hit), AW'(e.st));
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_comp[s] = '0; m_mask[s] = '0; m_func[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(dbg_event === 1'b0 && slot_hit === '0, "R1 outputs", AW'(slot_hit), '0);
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < 3; k++) reg_read(s, k, "R1 regs");

        // R11: layout and readback.
        reg_write(0, 0, 32'h2000_0100); reg_write(0, 1, 32'd4); reg_write(0, 2, 32'd5);
        reg_write(1, 0, 32'h2000_0200); reg_write(1, 1, 32'd0); reg_write(1, 2, 32'd6);
        reg_write(2, 0, 32'h3000_0000); reg_write(2, 1, 32'd12); reg_write(2, 2, 32'd7);
        reg_write(3, 2, 32'd3);
        reg_read(0, 0, "R11 comp"); reg_read(2, 1, "R11 mask");
        reg_read(1, 2, "R11 func"); reg_read(1, 3, "R11 sel3");

        trace_en = 1'b1;
        // R3: write-only slot.
        access(32'h2000_0104, 1'b0, 8'd3);
        access(32'h2000_010C, 1'b1, 8'd3);
        reg_read(0, 2, "R9 status readback");
        reg_read(0, 2, "R9 status cleared");
        // R2: region edges.
        access(32'h2000_0110, 1'b1, 8'd2);
        access(32'h2000_00FF, 1'b1, 8'd2);
        access(32'h2000_0100, 1'b1, 8'd2);
        // R4: read-only slot, exact address.
        access(32'h2000_0200, 1'b1, 8'd4);
        access(32'h2000_0200, 1'b0, 8'd4);
        access(32'h2000_0201, 1'b0, 8'd2);
        // R5: both directions, page region.
        access(32'h3000_0FFC, 1'b0, 8'd5);
        access(32'h3000_0ABC, 1'b1, 8'd5);
        access(32'h3000_1000, 1'b1, 8'd2);
        // R6: illegal code and disabled slot never hit on address 0.
        access(32'h0000_0000, 1'b1, 8'd6);
        reg_write(3, 2, 32'd0);
        access(32'h0000_0000, 1'b0, 8'd6);
        // R8: pulse lasts one cycle.
        @(negedge clk); @(negedge clk);
        check(dbg_event === 1'b0, "R8 pulse ended", AW'(dbg_event), '0);
        // R10: function write keeps status and drops upper bits.
        reg_write(2, 2, 32'h00FF_FF07);
        reg_read(2, 2, "R10 func write");
        check(slot_hit === m_stat, "R10 status kept", AW'(slot_hit), AW'(m_stat));
        // R9: clearing one slot keeps the others.
        reg_read(1, 2, "R9 clear slot1");
        @(negedge clk);
        check(slot_hit === m_stat, "R9 other slots kept", AW'(slot_hit), AW'(m_stat));
        // R7: trace disabled blocks everything.
        reg_read(0, 2, "R7 prep"); reg_read(2, 2, "R7 prep");
        trace_en = 1'b0;
        access(32'h3000_0010, 1'b1, 8'd7);
        access(32'h2000_0200, 1'b0, 8'd7);
        trace_en = 1'b1;
        // R2: multi-slot overlap.
        reg_write(3, 0, 32'h3000_0000); reg_write(3, 1, 32'd8); reg_write(3, 2, 32'd7);
        access(32'h3000_0044, 1'b0, 8'd2);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule